// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath unit of a small eight-bit microcontroller core. In the same evaluation it takes two operands, an operation code, a bit index and the current eight-bit status word. It returns a result, the next status word and a strobe that says whether the result is to be written back. The second operand carries either a register value or an immediate constant. The unit does not tell the two apart, so every immediate form of an operation uses the same code as its register form.

The unit covers several groups of operations:
- logic operations;
- addition and subtraction, each with and without the incoming carry;
- negation, increment and decrement;
- shifts, rotates through carry and nibble exchange;
- compares and a zero/minus test, which change only the flags;
- single-flag set and clear;
- transfer of a register bit to and from the transfer flag T.

Instruction decode, the register file and memory sit outside. The caller registers the outputs where it needs to.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are: 0 AND, 1 OR, 2 XOR, 3 complement, 4 add, 5 add with carry, 6 subtract, 7 subtract with carry, 8 negate, 9 increment, 10 decrement, 11 shift left, 12 logical shift right, 13 rotate left through carry, 14 rotate right through carry, 15 arithmetic shift right, 16 nibble swap, 17 compare, 18 compare with carry, 19 test, 20 flag set, 21 flag clear, 22 bit store, 23 bit load. Codes 17 to 22 and the unused codes 24 to 31 never raise `wr_o`. The unused codes return `sreg_o` equal to `sreg_i`. All other codes raise `wr_o`. `res_o` is meaningful only while `wr_o` is high.
- R2: Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. The logic operations (codes 0 to 3) clear V, set N from result bit 7 and set Z when the result is zero. Complement also sets C. AND, OR and XOR keep C and H.
- R3: Add and add-with-carry produce A+B (+C for code 5). C is the carry out of bit 7, H is the carry out of bit 3, and V marks two's-complement overflow.
- R4: Subtract, subtract-with-carry, compare and compare-with-carry evaluate A−B (−C for codes 7 and 18). C marks a borrow out of bit 7, H marks a borrow out of the low nibble, and V marks signed overflow.
- R5: For codes 7 and 18, Z becomes zero when the difference is nonzero and otherwise keeps its incoming value. For codes 6 and 17, Z is simply set when the difference is zero.
- R6: Negate produces 0−A. C is set when A is nonzero, V is set only when the result is 0x80, and H marks a nonzero low nibble of A.
- R7: Increment and decrement leave C and H unchanged. V is set only for the steps 0x7F→0x80 (increment) and 0x80→0x7F (decrement).
- R8: In shifts and rotates, C takes the bit shifted out. Logical shifts fill with zero, rotates fill from the incoming C, and the arithmetic right shift copies bit 7. N comes from the result, V equals N XOR C, and H is kept.
- R9: Nibble swap exchanges bits 7:4 and 3:0 of A and leaves every flag unchanged.
- R10: Test sets the flags exactly as AND of A with itself and writes no result.
- R11: Flag set and flag clear force the status bit chosen by `bit_i` to 1 or 0 and keep the other seven bits.
- R12: Bit store copies A[`bit_i`] into T and changes no other flag. Bit load returns A with bit `bit_i` replaced by the incoming T and changes no flag.
- R13: Every operation that updates N or V sets S to N XOR V. I is changed only by flag set or clear at index 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | W (8) | First operand, also the destination value |
| b_i | input | W (8) | Second operand: register or immediate |
| bit_i | input | log2(W) (3) | Bit index for flag and bit-transfer operations |
| sreg_i | input | 8 | Current status word |
| res_o | output | W (8) | Result value |
| sreg_o | output | 8 | Next status word |
| wr_o | output | 1 | Result write strobe |

## Verification
The bench builds the unit with its default width of eight. At that width every operand value is exact, so the nibble-based half-carry, the 0x7F/0x80 overflow edges and the 0x80 negate case are reached directly. A behavioural integer model computes the flags from signed and unsigned sums rather than from carry chains. That model is compared with the unit on every clock, first over directed corner vectors and then over random codes that include the unused ones. The chained zero flag of the carry-consuming subtractions is driven with the incoming Z both set and clear.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned FLAG_W = 8;

    typedef enum logic [4:0] {
        OP_AND  = 5'd0,
        OP_OR   = 5'd1,
        OP_XOR  = 5'd2,
        OP_COM  = 5'd3,
        OP_ADD  = 5'd4,
        OP_ADC  = 5'd5,
        OP_SUB  = 5'd6,
        OP_SBC  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_CMP  = 5'd17,
        OP_CPC  = 5'd18,
        OP_TST  = 5'd19,
        OP_FSET = 5'd20,
        OP_FCLR = 5'd21,
        OP_BST  = 5'd22,
        OP_BLD  = 5'd23
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL,
        SH_LSR,
        SH_ROL,
        SH_ROR,
        SH_ASR,
        SH_SWAP,
        SH_NONE
    } shift_e;

    typedef enum logic [1:0] {
        BM_SET,
        BM_CLR,
        BM_STORE,
        BM_LOAD
    } bitmode_e;

    // bit 7 down to bit 0
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam int unsigned FI_POS = 7;
    localparam int unsigned FT_POS = 6;

    function automatic logic uses_carry_in(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic is_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
               (op == OP_CPC) || (op == OP_NEG) || (op == OP_DEC);
    endfunction

    function automatic shift_e shift_of(alu_op_e op);
        case (op)
            OP_LSL:  return SH_LSL;
            OP_LSR:  return SH_LSR;
            OP_ROL:  return SH_ROL;
            OP_ROR:  return SH_ROR;
            OP_ASR:  return SH_ASR;
            OP_SWAP: return SH_SWAP;
            default: return SH_NONE;
        endcase
    endfunction

    function automatic bitmode_e bitmode_of(alu_op_e op);
        case (op)
            OP_FSET: return BM_SET;
            OP_FCLR: return BM_CLR;
            OP_BST:  return BM_STORE;
            default: return BM_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] r_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int HW = W / 2;

    logic [W-1:0] y_eff;
    logic         ci;
    logic [W:0]   full;
    logic [HW:0]  low;

    always_comb begin
        // subtraction as x + ~y + ~borrow_in
        y_eff = sub_i ? ~y_i : y_i;
        ci    = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci};
        low   = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, ci};
        r_o   = full[W-1:0];
        c_o   = full[W] ^ sub_i;
        h_o   = low[HW] ^ sub_i;
        v_o   = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0]          a_i,
    input  logic                  cin_i,
    input  alu8_pkg::shift_e      mode_i,
    output logic [W-1:0]          r_o,
    output logic                  c_o
);
    import alu8_pkg::*;
    localparam int HW = W / 2;

    always_comb begin
        r_o = a_i;
        c_o = cin_i;
        case (mode_i)
            SH_LSL: begin
                r_o = {a_i[W-2:0], 1'b0};
                c_o = a_i[W-1];
            end
            SH_LSR: begin
                r_o = {1'b0, a_i[W-1:1]};
                c_o = a_i[0];
            end
            SH_ROL: begin
                r_o = {a_i[W-2:0], cin_i};
                c_o = a_i[W-1];
            end
            SH_ROR: begin
                r_o = {cin_i, a_i[W-1:1]};
                c_o = a_i[0];
            end
            SH_ASR: begin
                r_o = {a_i[W-1], a_i[W-1:1]};
                c_o = a_i[0];
            end
            SH_SWAP: begin
                r_o = {a_i[HW-1:0], a_i[W-1:HW]};
            end
            default: begin
                r_o = a_i;
            end
        endcase
    end
endmodule

// File: rtl/alu8_bitop.sv
module alu8_bitop #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]                   a_i,
    input  logic [IW-1:0]                  idx_i,
    input  logic [alu8_pkg::FLAG_W-1:0]    flags_i,
    input  alu8_pkg::bitmode_e             mode_i,
    output logic [alu8_pkg::FLAG_W-1:0]    flags_o,
    output logic [W-1:0]                   r_o
);
    import alu8_pkg::*;

    logic [W-1:0]      dhit;
    logic [FLAG_W-1:0] fhit;
    logic              picked;
    logic              tbit;

    // one-hot select of the operand bit
    for (genvar k = 0; k < W; k++) begin : g_dsel
        assign dhit[k] = (idx_i == IW'(k));
    end

    // one-hot select of the status bit
    for (genvar k = 0; k < FLAG_W; k++) begin : g_fsel
        assign fhit[k] = ({{(32-IW){1'b0}}, idx_i} == 32'(k));
    end

    assign picked = |(a_i & dhit);
    assign tbit   = flags_i[FT_POS];

    always_comb begin
        flags_o = flags_i;
        r_o     = a_i;
        case (mode_i)
            BM_SET:   flags_o = flags_i | fhit;
            BM_CLR:   flags_o = flags_i & ~fhit;
            BM_STORE: flags_o[FT_POS] = picked;
            default:  r_o = (a_i & ~dhit) | (dhit & {W{tbit}});
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int W = alu8_pkg::DW
) (
    input  logic [4:0]             op_i,
    input  logic [W-1:0]           a_i,
    input  logic [W-1:0]           b_i,
    input  logic [$clog2(W)-1:0]   bit_i,
    input  logic [7:0]             sreg_i,
    output logic [W-1:0]           res_o,
    output logic [7:0]             sreg_o,
    output logic                   wr_o
);
    import alu8_pkg::*;

    localparam int IW = $clog2(W);

    alu_op_e      op;
    flags_t       f_in;
    flags_t       f_out;

    logic [W-1:0] as_x;
    logic [W-1:0] as_y;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_r;
    logic         as_c;
    logic         as_h;
    logic         as_v;

    logic [W-1:0] sh_r;
    logic         sh_c;

    logic [FLAG_W-1:0] bo_flags;
    logic [W-1:0]      bo_r;

    logic [W-1:0] lg_r;
    logic [W-1:0] res;
    logic         wr;

    assign op   = alu_op_e'(op_i);
    assign f_in = flags_t'(sreg_i);

    // operand steering for the adder/subtractor
    always_comb begin
        as_x   = a_i;
        as_y   = b_i;
        as_sub = is_subtract(op);
        as_cin = uses_carry_in(op) ? f_in.c : 1'b0;
        case (op)
            OP_NEG: begin
                as_x = '0;
                as_y = a_i;
            end
            OP_INC, OP_DEC: begin
                as_y = W'(1);
            end
            default: begin
                as_y = b_i;
            end
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x_i   (as_x),
        .y_i   (as_y),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .r_o   (as_r),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i    (a_i),
        .cin_i  (f_in.c),
        .mode_i (shift_of(op)),
        .r_o    (sh_r),
        .c_o    (sh_c)
    );

    alu8_bitop #(.W(W), .IW(IW)) u_bitop (
        .a_i     (a_i),
        .idx_i   (bit_i),
        .flags_i (sreg_i),
        .mode_i  (bitmode_of(op)),
        .flags_o (bo_flags),
        .r_o     (bo_r)
    );

    always_comb begin
        case (op)
            OP_AND, OP_TST: lg_r = a_i & ((op == OP_TST) ? a_i : b_i);
            OP_OR:          lg_r = a_i | b_i;
            OP_XOR:         lg_r = a_i ^ b_i;
            default:        lg_r = ~a_i;
        endcase
    end

    always_comb begin
        f_out = f_in;
        res   = a_i;
        wr    = 1'b0;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_TST: begin
                res     = lg_r;
                wr      = (op != OP_TST);
                f_out.v = 1'b0;
                f_out.n = lg_r[W-1];
                f_out.z = ~|lg_r;
                if (op == OP_COM) f_out.c = 1'b1;
                f_out.s = f_out.n ^ f_out.v;
            end
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
            OP_CMP, OP_CPC, OP_INC, OP_DEC: begin
                res     = as_r;
                wr      = (op != OP_CMP) && (op != OP_CPC);
                f_out.n = as_r[W-1];
                f_out.v = as_v;
                if ((op == OP_SBC) || (op == OP_CPC))
                    f_out.z = (~|as_r) & f_in.z;
                else
                    f_out.z = ~|as_r;
                if ((op != OP_INC) && (op != OP_DEC)) begin
                    f_out.c = as_c;
                    f_out.h = as_h;
                end
                f_out.s = f_out.n ^ f_out.v;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res     = sh_r;
                wr      = 1'b1;
                f_out.c = sh_c;
                f_out.n = sh_r[W-1];
                f_out.z = ~|sh_r;
                f_out.v = sh_r[W-1] ^ sh_c;
                f_out.s = f_out.n ^ f_out.v;
            end
            OP_SWAP: begin
                res = sh_r;
                wr  = 1'b1;
            end
            OP_FSET, OP_FCLR, OP_BST: begin
                f_out = flags_t'(bo_flags);
            end
            OP_BLD: begin
                res = bo_r;
                wr  = 1'b1;
            end
            default: begin
                f_out = f_in;
            end
        endcase
    end

    assign res_o  = res;
    assign sreg_o = f_out;
    assign wr_o   = wr;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = alu8_pkg::DW
) (
    input logic [4:0]           op_i,
    input logic [W-1:0]         a_i,
    input logic [7:0]           sreg_i,
    input logic [W-1:0]         res_o,
    input logic [7:0]           sreg_o,
    input logic                 wr_o
);
    import alu8_pkg::*;

    logic silent;
    logic nv_op;

    assign silent = (op_i >= 5'd17 && op_i <= 5'd22) || (op_i >= 5'd24);
    assign nv_op  = (op_i <= 5'd15) || (op_i == 5'd17) ||
                    (op_i == 5'd18) || (op_i == 5'd19);

    always_comb begin
        // R1
        no_write_chk: assert (!silent || !wr_o);
        // R1
        unused_keep_chk: assert (op_i < 5'd24 || sreg_o == sreg_i);
        // R13
        sign_rule_chk: assert (!nv_op || (sreg_o[4] == (sreg_o[2] ^ sreg_o[3])));
        // R5
        zero_chain_chk: assert (!((op_i == 5'd7) || (op_i == 5'd18)) ||
                                !sreg_o[1] || sreg_i[1]);
        // R13
        ienable_keep_chk: assert (op_i == 5'd20 || op_i == 5'd21 ||
                                  sreg_o[7] == sreg_i[7]);
        // R7
        incdec_carry_chk: assert (!(op_i == 5'd9 || op_i == 5'd10) ||
                                  (sreg_o[0] == sreg_i[0] && sreg_o[5] == sreg_i[5]));
        // R9
        swap_flags_chk: assert (op_i != 5'd16 || (sreg_o == sreg_i && wr_o));
        // R2
        logic_zero_chk: assert (!(op_i <= 5'd3) || (sreg_o[1] == (res_o == '0)));
    end

    logic unused_a;
    assign unused_a = ^a_i;

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .op_i   (op_i),
    .a_i    (a_i),
    .sreg_i (sreg_i),
    .res_o  (res_o),
    .sreg_o (sreg_o),
    .wr_o   (wr_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = 5'd31;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] bit_i = '0;
    logic [7:0] sreg_i = '0;
    logic [7:0] res_o;
    logic [7:0] sreg_o;
    logic       wr_o;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    alu8_core dut (
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .bit_i  (bit_i),
        .sreg_i (sreg_i),
        .res_o  (res_o),
        .sreg_o (sreg_o),
        .wr_o   (wr_o)
    );

    function automatic string req_of(int op);
        if (op <= 3) return "R2";
        if (op <= 5) return "R3";
        if (op <= 7 || op == 17 || op == 18) return "R4";
        if (op == 8) return "R6";
        if (op <= 10) return "R7";
        if (op <= 15) return "R8";
        if (op == 16) return "R9";
        if (op == 19) return "R10";
        if (op <= 21) return "R11";
        if (op <= 23) return "R12";
        return "R1";
    endfunction

    function automatic int sgn(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // behavioural reference: integer arithmetic on whole values
    function automatic void model(input int op, input int a, input int b,
                                  input int bi, input int sr,
                                  output int r, output int so, output bit w);
        int c, z, n, v, s, h, t, i, d, sv, cin;
        bit upd;
        c = sr % 2; z = (sr / 2) % 2; n = (sr / 4) % 2; v = (sr / 8) % 2;
        s = (sr / 16) % 2; h = (sr / 32) % 2; t = (sr / 64) % 2; i = sr / 128;
        r = a; w = 0; upd = 0; so = sr;
        case (op)
            0: begin r = a & b; v = 0; upd = 1; w = 1; end
            1: begin r = a | b; v = 0; upd = 1; w = 1; end
            2: begin r = a ^ b; v = 0; upd = 1; w = 1; end
            3: begin r = 255 - a; v = 0; c = 1; upd = 1; w = 1; end
            19: begin r = a; v = 0; upd = 1; end
            4, 5: begin
                cin = (op == 5) ? c : 0;
                d = a + b + cin;
                r = d % 256;
                c = (d > 255);
                h = ((a % 16) + (b % 16) + cin) > 15;
                sv = sgn(a) + sgn(b) + cin;
                v = (sv > 127 || sv < -128);
                upd = 1; w = 1;
            end
            6, 7, 17, 18: begin
                cin = (op == 7 || op == 18) ? c : 0;
                d = a - b - cin;
                r = (d + 256) % 256;
                c = (d < 0);
                h = ((a % 16) - (b % 16) - cin) < 0;
                sv = sgn(a) - sgn(b) - cin;
                v = (sv > 127 || sv < -128);
                upd = 1; w = (op == 6 || op == 7);
            end
            8: begin
                r = (256 - a) % 256;
                c = (a != 0);
                h = (a % 16) != 0;
                v = (r == 128);
                upd = 1; w = 1;
            end
            9:  begin r = (a + 1) % 256; v = (r == 128); upd = 1; w = 1; end
            10: begin r = (a + 255) % 256; v = (r == 127); upd = 1; w = 1; end
            11: begin r = (a * 2) % 256; c = (a >= 128); upd = 2'd1; w = 1; end
            12: begin r = a / 2; c = a % 2; upd = 1; w = 1; end
            13: begin r = (a * 2 + c) % 256; c = (a >= 128); upd = 1; w = 1; end
            14: begin r = a / 2 + c * 128; c = a % 2; upd = 1; w = 1; end
            15: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; upd = 1; w = 1; end
            16: begin r = (a % 16) * 16 + a / 16; w = 1; end
            22: begin t = (a >> bi) & 1; end
            23: begin
                r = t ? (a | (1 << bi)) : (a & ~(1 << bi) & 255);
                w = 1;
            end
            default: ;
        endcase
        if (upd) begin
            n = (r >= 128);
            if (op == 7 || op == 18) z = (r == 0) && (z == 1);
            else z = (r == 0);
            if (op >= 11 && op <= 15) v = n ^ c;
            s = n ^ v;
        end
        so = c + 2 * z + 4 * n + 8 * v + 16 * s + 32 * h + 64 * t + 128 * i;
        if (op == 20) so = sr | (1 << bi);
        if (op == 21) so = sr & ~(1 << bi) & 255;
    endfunction

    task automatic run(input string tag, input int op, input int a, input int b,
                       input int bi, input int sr);
        int er, es;
        bit ew;
        @(posedge clk);
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; bit_i = bi[2:0]; sreg_i = sr[7:0];
        @(negedge clk);
        model(op, a, b, bi, sr, er, es, ew);
        checks++;
        if (wr_o !== ew || (ew && res_o !== er[7:0]) || sreg_o !== es[7:0]) begin
            bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h bit=%0d sreg=%02h: got res=%02h sreg=%02h wr=%0b exp res=%02h sreg=%02h wr=%0b",
                     tag, op, a, b, bi, sr, res_o, sreg_o, wr_o, er[7:0], es[7:0], ew);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 idle code after reset, compare writes nothing
        run("R1", 31, 8'h5A, 8'h33, 0, 8'hA5);
        run("R1", 24, 8'h00, 8'h00, 0, 8'h00);
        run("R1", 17, 8'h10, 8'h10, 0, 8'h00);
        // R2 logic clears V, complement sets C
        run("R2", 0, 8'hF0, 8'h3C, 0, 8'h08);
        run("R2", 3, 8'h00, 8'h00, 0, 8'h00);
        run("R2", 2, 8'hAA, 8'hAA, 0, 8'h21);
        // R3 add edges
        run("R3", 4, 8'h7F, 8'h01, 0, 8'h00);
        run("R3", 4, 8'hFF, 8'h01, 0, 8'h00);
        run("R3", 5, 8'h0F, 8'h00, 0, 8'h01);
        // R4 subtract edges
        run("R4", 6, 8'h00, 8'h01, 0, 8'h00);
        run("R4", 6, 8'h80, 8'h01, 0, 8'h00);
        run("R4", 17, 8'h10, 8'h11, 0, 8'h00);
        // R5 zero chaining
        run("R5", 18, 8'h22, 8'h22, 0, 8'h02);
        run("R5", 18, 8'h22, 8'h22, 0, 8'h00);
        run("R5", 7, 8'h05, 8'h04, 0, 8'h03);
        run("R5", 6, 8'h05, 8'h05, 0, 8'h00);
        // R6 negate
        run("R6", 8, 8'h00, 8'h00, 0, 8'h00);
        run("R6", 8, 8'h80, 8'h00, 0, 8'h00);
        run("R6", 8, 8'h01, 8'h00, 0, 8'h00);
        // R7 increment / decrement keep C and H
        run("R7", 9, 8'h7F, 8'h00, 0, 8'h21);
        run("R7", 9, 8'hFF, 8'h00, 0, 8'h00);
        run("R7", 10, 8'h80, 8'h00, 0, 8'h21);
        run("R7", 10, 8'h00, 8'h00, 0, 8'h00);
        // R8 shifts and rotates
        run("R8", 13, 8'h80, 8'h00, 0, 8'h00);
        run("R8", 14, 8'h01, 8'h00, 0, 8'h01);
        run("R8", 15, 8'h81, 8'h00, 0, 8'h20);
        run("R8", 12, 8'h01, 8'h00, 0, 8'h00);
        run("R8", 11, 8'h40, 8'h00, 0, 8'h00);
        // R9 swap
        run("R9", 16, 8'h3C, 8'h00, 0, 8'hFF);
        // R10 test
        run("R10", 19, 8'h00, 8'hFF, 0, 8'h00);
        run("R10", 19, 8'h80, 8'h00, 0, 8'h0F);
        // R11 flag set / clear at every index
        for (int k = 0; k < 8; k++) begin
            run("R11", 20, 8'h00, 8'h00, k, 8'h00);
            run("R11", 21, 8'h00, 8'h00, k, 8'hFF);
        end
        // R12 bit store / load
        run("R12", 22, 8'h08, 8'h00, 3, 8'h00);
        run("R12", 22, 8'hF7, 8'h00, 3, 8'hFF);
        run("R12", 23, 8'h00, 8'h00, 5, 8'h40);
        run("R12", 23, 8'hFF, 8'h00, 0, 8'h00);
        // R13 sign rule with N and V both set
        run("R13", 4, 8'h40, 8'h40, 0, 8'h00);
        run("R13", 6, 8'h7F, 8'hFF, 0, 8'h80);
        // random sweep including unused codes
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = $urandom_range(0, 31);
            run(req_of(op), op, $urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 7), $urandom_range(0, 255));
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule